// File: doc/BRIEF.md
# Address-Space-Tagged Set-Associative Translation Cache

This block caches virtual-to-physical page translations. It holds 4 sets of 4 ways. Each entry stores a tag, an address-space identifier, a global flag, a physical page number and a field of permission bits. A lookup presents a virtual page number and the requester's address-space identifier. Within the same cycle, and with no memory access, the block returns a hit flag, the physical page number, the permission bits and the entry's global flag.

A page walker outside this block services misses. It writes the translation it fetched through the fill port, and the access is then retried. Entries carry address-space identifiers, so they survive a context switch. A flush can remove everything, or only the non-global entries of one address space.

Each cycle the control inputs are decoded into one command, by priority: OP_WIPE_ALL, then OP_WIPE_ASID, then OP_FILL, then OP_IDLE. Every set acts on that command at the next clock edge. There is no other state sequence. The only per-set control state is a round-robin victim pointer, which moves from way 0 to way 3 and then wraps back to 0.

Top module: `xc_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: Bits [1:0] of the virtual page number select the set, and bits [7:2] form the tag. For example, page 0x0F is set 3 with tag 0x03, and page 0x2E is set 2 with tag 0x0B. A stored entry hits only for a page number with both the same set and the same tag.
- R3: A lookup hits when a valid entry in the selected set has a matching tag and either its global flag is set or its identifier equals `lk_asid`. The entry's page number, permission bits and global flag appear in the same cycle.
- R4: On a miss, `lk_ppn`, `lk_perm` and `lk_glob` are all zero.
- R5: A fill becomes visible to lookups in the cycle after it is presented. A lookup made in the fill cycle itself sees the contents from before the fill.
- R6: A fill goes to the lowest-numbered invalid way of its set. A set filled from empty therefore occupies ways 0, 1, 2 and 3 in fill order.
- R7: When all four ways of a set are valid, a fill evicts the way chosen by that set's round-robin pointer. The pointer starts at way 0 after reset and advances by one, wrapping, only on such evicting fills. Each set has its own pointer.
- R8: A fill whose tag matches a valid entry, where that entry is global or has the fill's identifier, overwrites that entry in place. It evicts nothing and leaves the pointer unchanged.
- R9: `wipe_all` invalidates every entry at the next edge. Lookups in the following cycle all miss.
- R10: `wipe_asid_en` invalidates, at the next edge, only the non-global entries whose identifier equals `wipe_asid`. Global entries and entries of other address spaces still hit.
- R11: A fill presented in the same cycle as either wipe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 8 | Lookup virtual page number |
| lk_asid | input | 4 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 6 | Physical page number on a hit |
| lk_perm | output | 3 | Permission bits on a hit |
| lk_glob | output | 1 | Global flag of the hitting entry |
| fl_en | input | 1 | Fill strobe |
| fl_vpn | input | 8 | Fill virtual page number |
| fl_asid | input | 4 | Fill address-space identifier |
| fl_ppn | input | 6 | Fill physical page number |
| fl_perm | input | 3 | Fill permission bits |
| fl_glob | input | 1 | Fill global flag |
| wipe_all | input | 1 | Invalidate all entries |
| wipe_asid_en | input | 1 | Invalidate non-global entries of one identifier |
| wipe_asid | input | 4 | Identifier to invalidate |

## Verification
Faults in the valid bits or the stored tags show up on the very next lookup of the affected page, as a false hit or a false miss. A wrong page number also appears in that same lookup.

A victim pointer that drifts, or that moves on an in-place refill, does not show up at once. It appears only one evicting fill later, when the wrong earlier page goes missing. The directed sequences are therefore built so that each eviction is followed by lookups of every page in the set.

A flush that is too broad or too narrow shows up in the cycle after the wipe, through lookups from other address spaces and of global entries.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [1:0] {
        OP_IDLE,
        OP_FILL,
        OP_WIPE_ALL,
        OP_WIPE_ASID
    } xc_op_e;
endpackage

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int WAYS = 4,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] valid_i,
    input  logic [WAYS-1:0] match_i,
    input  logic [WIDX-1:0] rr_i,
    output logic [WAYS-1:0] way_o,
    output logic            evict_o
);
    logic found;

    always_comb begin
        way_o   = '0;
        evict_o = 1'b0;
        found   = 1'b0;
        // an existing translation for the same page is refreshed in place
        for (int w = 0; w < WAYS; w++) begin
            if (!found && match_i[w]) begin
                way_o[w] = 1'b1;
                found    = 1'b1;
            end
        end
        // otherwise take the lowest free way
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_i[w]) begin
                way_o[w] = 1'b1;
                found    = 1'b1;
            end
        end
        if (!found) begin
            way_o[rr_i] = 1'b1;
            evict_o     = 1'b1;
        end
    end
endmodule

// File: rtl/xc_set.sv
module xc_set
    import xc_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 6,
    parameter int PPN_W  = 6,
    parameter int PERM_W = 3,
    parameter int ASID_W = 4,
    localparam int WIDX  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xc_op_e            op_i,
    input  logic              sel_i,
    input  logic [TAG_W-1:0]  fl_tag_i,
    input  logic [ASID_W-1:0] fl_asid_i,
    input  logic [PPN_W-1:0]  fl_ppn_i,
    input  logic [PERM_W-1:0] fl_perm_i,
    input  logic              fl_glob_i,
    input  logic [ASID_W-1:0] wipe_asid_i,
    input  logic [TAG_W-1:0]  lk_tag_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    output logic              hit_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [PERM_W-1:0] perm_o,
    output logic              glob_o
);
    logic [WAYS-1:0]   vld_q;
    logic [WAYS-1:0]   glb_q;
    logic [TAG_W-1:0]  tag_q  [WAYS];
    logic [ASID_W-1:0] asid_q [WAYS];
    logic [PPN_W-1:0]  ppn_q  [WAYS];
    logic [PERM_W-1:0] perm_q [WAYS];
    logic [WIDX-1:0]   rr_q;

    logic [WAYS-1:0] lk_hitv;
    logic [WAYS-1:0] fl_match;
    logic [WAYS-1:0] fl_way;
    logic            fl_evict;
    logic            do_fill;

    assign do_fill = (op_i == OP_FILL) && sel_i;

    // per-way compare for lookup and for fill refresh
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign lk_hitv[w]  = vld_q[w] && (tag_q[w] == lk_tag_i) &&
                                 (glb_q[w] || (asid_q[w] == lk_asid_i));
            assign fl_match[w] = vld_q[w] && (tag_q[w] == fl_tag_i) &&
                                 (glb_q[w] || (asid_q[w] == fl_asid_i));
        end
    endgenerate

    xc_victim #(.WAYS(WAYS)) u_victim (
        .valid_i (vld_q),
        .match_i (fl_match),
        .rr_i    (rr_q),
        .way_o   (fl_way),
        .evict_o (fl_evict)
    );

    // control state: valid bits and victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else begin
            unique case (op_i)
                OP_WIPE_ALL: vld_q <= '0;
                OP_WIPE_ASID: begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (!glb_q[w] && (asid_q[w] == wipe_asid_i)) vld_q[w] <= 1'b0;
                    end
                end
                OP_FILL: begin
                    if (sel_i) begin
                        vld_q <= vld_q | fl_way;
                        if (fl_evict) begin
                            rr_q <= (rr_q == WIDX'(WAYS-1)) ? '0 : rr_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (do_fill) begin
            for (int w = 0; w < WAYS; w++) begin
                if (fl_way[w]) begin
                    tag_q[w]  <= fl_tag_i;
                    asid_q[w] <= fl_asid_i;
                    ppn_q[w]  <= fl_ppn_i;
                    perm_q[w] <= fl_perm_i;
                    glb_q[w]  <= fl_glob_i;
                end
            end
        end
    end

    // output selection, zero on miss
    always_comb begin
        ppn_o  = '0;
        perm_o = '0;
        glob_o = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_hitv[w]) begin
                ppn_o  = ppn_o  | ppn_q[w];
                perm_o = perm_o | perm_q[w];
                glob_o = glob_o | glb_q[w];
            end
        end
    end

    assign hit_o = |lk_hitv;
endmodule

// File: rtl/xc_top.sv
module xc_top
    import xc_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int VPN_W  = 8,
    parameter int PPN_W  = 6,
    parameter int PERM_W = 3,
    parameter int ASID_W = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_glob,
    input  logic              fl_en,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              fl_glob,
    input  logic              wipe_all,
    input  logic              wipe_asid_en,
    input  logic [ASID_W-1:0] wipe_asid
);
    xc_op_e op;

    // command decode by priority
    always_comb begin
        if (wipe_all)          op = OP_WIPE_ALL;
        else if (wipe_asid_en) op = OP_WIPE_ASID;
        else if (fl_en)        op = OP_FILL;
        else                   op = OP_IDLE;
    end

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fl_idx;
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign fl_idx = fl_vpn[IDX_W-1:0];

    logic              s_hit  [SETS];
    logic [PPN_W-1:0]  s_ppn  [SETS];
    logic [PERM_W-1:0] s_perm [SETS];
    logic              s_glob [SETS];

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set
            xc_set #(
                .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W),
                .PERM_W(PERM_W), .ASID_W(ASID_W)
            ) u_set (
                .clk         (clk),
                .rst_n       (rst_n),
                .op_i        (op),
                .sel_i       (fl_idx == IDX_W'(s)),
                .fl_tag_i    (fl_vpn[VPN_W-1:IDX_W]),
                .fl_asid_i   (fl_asid),
                .fl_ppn_i    (fl_ppn),
                .fl_perm_i   (fl_perm),
                .fl_glob_i   (fl_glob),
                .wipe_asid_i (wipe_asid),
                .lk_tag_i    (lk_vpn[VPN_W-1:IDX_W]),
                .lk_asid_i   (lk_asid),
                .hit_o       (s_hit[s]),
                .ppn_o       (s_ppn[s]),
                .perm_o      (s_perm[s]),
                .glob_o      (s_glob[s])
            );
        end
    endgenerate

    assign lk_hit  = s_hit[lk_idx];
    assign lk_ppn  = s_ppn[lk_idx];
    assign lk_perm = s_perm[lk_idx];
    assign lk_glob = s_glob[lk_idx];
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
    parameter int VPN_W  = 8,
    parameter int PPN_W  = 6,
    parameter int PERM_W = 3,
    parameter int ASID_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [PERM_W-1:0] lk_perm,
    input logic              lk_glob,
    input logic              fl_en,
    input logic [VPN_W-1:0]  fl_vpn,
    input logic [ASID_W-1:0] fl_asid,
    input logic [PPN_W-1:0]  fl_ppn,
    input logic [PERM_W-1:0] fl_perm,
    input logic              wipe_all,
    input logic              wipe_asid_en,
    input logic [ASID_W-1:0] wipe_asid
);
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && lk_perm == '0 && !lk_glob));

    // R9
    wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_all |=> !lk_hit);

    // R5
    fill_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !wipe_all && !wipe_asid_en) |=>
        (!(lk_vpn == $past(fl_vpn) && lk_asid == $past(fl_asid)) ||
         (lk_hit && lk_ppn == $past(fl_ppn) && lk_perm == $past(fl_perm))));

    // R10
    wipe_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_asid_en && !wipe_all) |=>
        (!(lk_hit && lk_asid == $past(wipe_asid)) || lk_glob));
endmodule

bind xc_top xc_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .ASID_W(ASID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_glob(lk_glob),
    .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_ppn(fl_ppn),
    .fl_perm(fl_perm), .wipe_all(wipe_all), .wipe_asid_en(wipe_asid_en),
    .wipe_asid(wipe_asid)
);

// File: tb/xc_top_bench.sv
`timescale 1ns/1ps
module xc_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic [3:0] lk_asid = '0;
    logic       lk_hit;
    logic [5:0] lk_ppn;
    logic [2:0] lk_perm;
    logic       lk_glob;
    logic       fl_en = 1'b0;
    logic [7:0] fl_vpn = '0;
    logic [3:0] fl_asid = '0;
    logic [5:0] fl_ppn = '0;
    logic [2:0] fl_perm = '0;
    logic       fl_glob = 1'b0;
    logic       wipe_all = 1'b0;
    logic       wipe_asid_en = 1'b0;
    logic [3:0] wipe_asid = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xc_top u_xc_top (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_glob(lk_glob),
        .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asid(fl_asid), .fl_ppn(fl_ppn),
        .fl_perm(fl_perm), .fl_glob(fl_glob), .wipe_all(wipe_all),
        .wipe_asid_en(wipe_asid_en), .wipe_asid(wipe_asid)
    );

    // expected word = {hit, glob, perm, ppn}; a miss expects all zero (R4)
    task automatic expect_lk(input string req, input logic [7:0] vpn, input logic [3:0] asid,
                             input logic hit, input logic glob, input logic [2:0] perm,
                             input logic [5:0] ppn);
        logic [10:0] exp_w, act_w;
        lk_vpn  = vpn;
        lk_asid = asid;
        #1;
        exp_w = hit ? {hit, glob, perm, ppn} : 11'h0;
        act_w = {lk_hit, lk_glob, lk_perm, lk_ppn};
        total++;
        if (act_w !== exp_w) begin
            bad++;
            $display("FAIL %s vpn=%h asid=%0d actual=%h expected=%h", req, vpn, asid, act_w, exp_w);
        end
    endtask

    task automatic fill(input logic [7:0] vpn, input logic [3:0] asid, input logic [5:0] ppn,
                        input logic [2:0] perm, input logic glob);
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = vpn; fl_asid = asid; fl_ppn = ppn;
        fl_perm = perm; fl_glob = glob;
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        expect_lk("R1", 8'h00, 4'd0, 0, 0, 0, 0);
        expect_lk("R1", 8'h0F, 4'd1, 0, 0, 0, 0);
        expect_lk("R1", 8'hFF, 4'd15, 0, 0, 0, 0);
    endtask

    task automatic t_split();
        fill(8'h0F, 4'd1, 6'h0D, 3'd5, 1'b0);
        expect_lk("R3", 8'h0F, 4'd1, 1, 0, 3'd5, 6'h0D);
        expect_lk("R3", 8'h0F, 4'd2, 0, 0, 0, 0);
        // R2: same tag other set, same set other tag
        expect_lk("R2", 8'h0E, 4'd1, 0, 0, 0, 0);
        expect_lk("R2", 8'h0B, 4'd1, 0, 0, 0, 0);
        expect_lk("R2", 8'h1F, 4'd1, 0, 0, 0, 0);
    endtask

    task automatic t_global();
        fill(8'h2E, 4'd3, 6'h11, 3'd7, 1'b1);
        expect_lk("R3", 8'h2E, 4'd9, 1, 1, 3'd7, 6'h11);
        expect_lk("R2", 8'h2A, 4'd3, 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = 8'h40; fl_asid = 4'd2; fl_ppn = 6'h20;
        fl_perm = 3'd2; fl_glob = 1'b0;
        // R5: pre-fill contents in the fill cycle
        expect_lk("R5", 8'h40, 4'd2, 0, 0, 0, 0);
        @(negedge clk);
        fl_en = 1'b0;
        expect_lk("R5", 8'h40, 4'd2, 1, 0, 3'd2, 6'h20);
    endtask

    task automatic t_replace();
        // set 1 fills ways 0..3 (R6)
        fill(8'h01, 4'd1, 6'd1, 3'd1, 1'b0);
        fill(8'h05, 4'd1, 6'd2, 3'd1, 1'b0);
        fill(8'h09, 4'd1, 6'd3, 3'd1, 1'b0);
        fill(8'h0D, 4'd1, 6'd4, 3'd1, 1'b0);
        expect_lk("R6", 8'h01, 4'd1, 1, 0, 3'd1, 6'd1);
        expect_lk("R6", 8'h0D, 4'd1, 1, 0, 3'd1, 6'd4);
        fill(8'h11, 4'd1, 6'd5, 3'd1, 1'b0);
        expect_lk("R7", 8'h01, 4'd1, 0, 0, 0, 0);
        expect_lk("R7", 8'h05, 4'd1, 1, 0, 3'd1, 6'd2);
        expect_lk("R7", 8'h11, 4'd1, 1, 0, 3'd1, 6'd5);
        fill(8'h15, 4'd1, 6'd6, 3'd1, 1'b0);
        expect_lk("R7", 8'h05, 4'd1, 0, 0, 0, 0);
        expect_lk("R7", 8'h09, 4'd1, 1, 0, 3'd1, 6'd3);
        // R8: refresh in place, nothing evicted, pointer still at way 2
        fill(8'h09, 4'd1, 6'h3F, 3'd1, 1'b0);
        expect_lk("R8", 8'h09, 4'd1, 1, 0, 3'd1, 6'h3F);
        expect_lk("R8", 8'h0D, 4'd1, 1, 0, 3'd1, 6'd4);
        expect_lk("R8", 8'h11, 4'd1, 1, 0, 3'd1, 6'd5);
        expect_lk("R8", 8'h15, 4'd1, 1, 0, 3'd1, 6'd6);
        fill(8'h19, 4'd1, 6'd7, 3'd1, 1'b0);
        expect_lk("R8", 8'h09, 4'd1, 0, 0, 0, 0);
        expect_lk("R8", 8'h0D, 4'd1, 1, 0, 3'd1, 6'd4);
        expect_lk("R8", 8'h19, 4'd1, 1, 0, 3'd1, 6'd7);
    endtask

    task automatic t_per_set_ptr();
        // set 0 pointer is still at way 0 although set 1 has moved (R7)
        fill(8'h44, 4'd2, 6'h21, 3'd2, 1'b0);
        fill(8'h48, 4'd2, 6'h22, 3'd2, 1'b0);
        fill(8'h4C, 4'd2, 6'h23, 3'd2, 1'b0);
        fill(8'h50, 4'd2, 6'h24, 3'd2, 1'b0);
        expect_lk("R7", 8'h40, 4'd2, 0, 0, 0, 0);
        expect_lk("R7", 8'h44, 4'd2, 1, 0, 3'd2, 6'h21);
        expect_lk("R7", 8'h50, 4'd2, 1, 0, 3'd2, 6'h24);
    endtask

    task automatic t_wipe_asid();
        @(negedge clk);
        wipe_asid_en = 1'b1; wipe_asid = 4'd1;
        fl_en = 1'b1; fl_vpn = 8'h33; fl_asid = 4'd2; fl_ppn = 6'h2A;
        fl_perm = 3'd4; fl_glob = 1'b0;
        @(negedge clk);
        wipe_asid_en = 1'b0; fl_en = 1'b0;
        expect_lk("R10", 8'h0F, 4'd1, 0, 0, 0, 0);
        expect_lk("R10", 8'h19, 4'd1, 0, 0, 0, 0);
        expect_lk("R10", 8'h2E, 4'd1, 1, 1, 3'd7, 6'h11);
        expect_lk("R10", 8'h44, 4'd2, 1, 0, 3'd2, 6'h21);
        expect_lk("R11", 8'h33, 4'd2, 0, 0, 0, 0);
    endtask

    task automatic t_wipe_all();
        @(negedge clk);
        wipe_all = 1'b1;
        fl_en = 1'b1; fl_vpn = 8'h30; fl_asid = 4'd2; fl_ppn = 6'h30;
        fl_perm = 3'd1; fl_glob = 1'b1;
        @(negedge clk);
        wipe_all = 1'b0; fl_en = 1'b0;
        expect_lk("R9", 8'h2E, 4'd3, 0, 0, 0, 0);
        expect_lk("R9", 8'h44, 4'd2, 0, 0, 0, 0);
        expect_lk("R11", 8'h30, 4'd2, 0, 0, 0, 0);
        // refill after wipe starts from way 0 again
        fill(8'h30, 4'd2, 6'h30, 3'd1, 1'b0);
        expect_lk("R5", 8'h30, 4'd2, 1, 0, 3'd1, 6'h30);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split();
        t_global();
        t_same_cycle();
        t_replace();
        t_per_set_ptr();
        t_wipe_asid();
        t_wipe_all();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule